// File: doc/BRIEF.md
# GPIO Interrupt Cause Controller

A bank of general-purpose lines with a per-line direction, output latch and input inversion setting, plus an interrupt front end. Each incoming line is synchronized by two flops and then XORed with its inversion bit. The result is the input data that software reads, and it drives two interrupt sources. The level source uses that input data directly, gated by a per-line level enable. The edge source records rising transitions of that input data in a sticky per-line flag, gated by a separate per-line edge enable.

The two gated sources are ORed per line. The per-line results are then ORed in groups of eight lines, giving one registered summary interrupt per group. Software reaches the registers through a flat word-addressed bus: a byte address, a write strobe, write data, and read data that is returned in the same cycle. Writing 0 to a bit of the edge flag register clears that bit.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the output latch, the inversion register, the edge flags, the edge enables and the level enables are all zero. The direction register is all ones, so every line is an input. `gpio_oe_o` and `irq_o` are zero.
- R2: For an input line, the data read at address 0x0C equals the line value XOR its inversion bit at address 0x08, where 1 inverts. A change on `gpio_i` shows up at that read after two clock edges. A change to the inversion bit shows up at once.
- R3: A direction bit (address 0x04) of 0 makes the line an output. `gpio_o` then carries the output latch (address 0x00), `gpio_oe_o` is set, and the read at 0x0C returns the latch bit instead of the line.
- R4: Level source: a line whose level enable bit (address 0x18) is 1 asserts its group interrupt for as long as its inverted input data is 1.
- R5: An edge flag (address 0x10) is set by a 0-to-1 change of the inverted input data. With inversion 1, a falling line sets the flag and a rising line does not.
- R6: Edge flags are sticky. A write to 0x10 clears each bit written as 0 and keeps each bit written as 1.
- R7: A set edge flag asserts its group interrupt only while its edge enable bit (address 0x14) is 1. The edge enables and the level enables act independently of each other.
- R8: `irq_o[g]` is the OR of the enabled causes of lines 8g to 8g+7. It is registered, so it changes one edge after the cause does, and three edges after a line change.
- R9: Changing an inversion bit while the line is static is treated as a transition of the inverted input and can set the edge flag.
- R10: When an edge arrives in the same cycle as a write of 0 to its flag, the flag stays set.
- R11: The registers at 0x00, 0x04, 0x08, 0x14 and 0x18 read back the value written. Writes to 0x0C have no effect. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Byte address of the register, word aligned |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, same cycle |
| gpio_i | input | 32 | Raw line inputs |
| gpio_o | output | 32 | Output latch value |
| gpio_oe_o | output | 32 | Output enable per line (1 = line is an output) |
| irq_o | output | 4 | Summary interrupt per group of eight lines |

## Verification
The hardest situation to reach is an edge and a software clear of the same flag landing on one clock edge. This requires knowing exactly when the synchronized, inverted input changes. The bench drives the line on a falling clock edge and lets two rising edges pass through the synchronizer. It then raises the write of zero to the flag register on the next half cycle, so the write and the edge detection are sampled together.

A second delicate case is an edge created only by an inversion write. The bench reaches it by flipping the inversion bit while the line is held still.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_OUT   = 5'h00,
    REG_DIR   = 5'h04,
    REG_INV   = 5'h08,
    REG_DIN   = 5'h0C,
    REG_EFLAG = 5'h10,
    REG_EEN   = 5'h14,
    REG_LEN   = 5'h18
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_edge_flag.sv
module gpio_edge_flag #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] keep_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] prev_q, flag_q, rise_w, kept_w;

  assign rise_w = data_i & ~prev_q;
  assign kept_w = clr_en_i ? (flag_q & keep_i) : flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= data_i;
      flag_q <= kept_w | rise_w;  // new edge beats a clear
    end
  end

  assign flag_o = flag_q;

  // R6
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_en_i |=> (($past(flag_q) & ~flag_q) == '0));

  // R5
  flag_set_by_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(data_i & ~prev_q)) == '0));

  // R10
  edge_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((flag_q & $past(data_i & ~prev_q)) == $past(data_i & ~prev_q)));
endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or #(
  parameter int unsigned W       = 32,
  parameter int unsigned GROUP_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [W-1:0]           cause_i,
  output logic [W/GROUP_W-1:0]   irq_o
);
  localparam int unsigned NG = W / GROUP_W;

  logic [NG-1:0] irq_q;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[g] <= 1'b0;
      else         irq_q[g] <= |cause_i[g*GROUP_W +: GROUP_W];
    end
  end

  assign irq_o = irq_q;

  // R8
  no_cause_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i == '0) |=> (irq_o == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned GROUP_W  = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        we_i,
  input  logic [NUM_PINS-1:0]         wdata_i,
  output logic [NUM_PINS-1:0]         rdata_o,
  input  logic [NUM_PINS-1:0]         gpio_i,
  output logic [NUM_PINS-1:0]         gpio_o,
  output logic [NUM_PINS-1:0]         gpio_oe_o,
  output logic [NUM_PINS/GROUP_W-1:0] irq_o
);
  localparam int unsigned NG = NUM_PINS / GROUP_W;

  logic [NUM_PINS-1:0] out_q, dir_q, inv_q, een_q, len_q;
  logic [NUM_PINS-1:0] sync_w, din_w, flag_w, cause_w;
  logic                flag_clr_w;

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (sync_w)
  );

  assign din_w = sync_w ^ inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '1;
      inv_q <= '0;
      een_q <= '0;
      len_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_OUT: out_q <= wdata_i;
        REG_DIR: dir_q <= wdata_i;
        REG_INV: inv_q <= wdata_i;
        REG_EEN: een_q <= wdata_i;
        REG_LEN: len_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign flag_clr_w = we_i && (addr_i == REG_EFLAG);

  gpio_edge_flag #(.W(NUM_PINS)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (din_w),
    .clr_en_i(flag_clr_w),
    .keep_i  (wdata_i),
    .flag_o  (flag_w)
  );

  assign cause_w = (din_w & len_q) | (flag_w & een_q);

  gpio_group_or #(.W(NUM_PINS), .GROUP_W(GROUP_W)) u_grp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cause_i(cause_w),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_OUT:   rdata_o = out_q;
      REG_DIR:   rdata_o = dir_q;
      REG_INV:   rdata_o = inv_q;
      REG_DIN:   rdata_o = (din_w & dir_q) | (out_q & ~dir_q);
      REG_EFLAG: rdata_o = flag_w;
      REG_EEN:   rdata_o = een_q;
      REG_LEN:   rdata_o = len_q;
      default:   rdata_o = '0;
    endcase
  end

  assign gpio_o    = out_q;
  assign gpio_oe_o = ~dir_q;

  // R4
  masks_off_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q == '0 && een_q == '0) |=> (irq_o == '0));

  // R3
  oe_matches_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(dir_q) |-> $stable(gpio_oe_o));

  initial begin
    // R8
    group_div_chk: assert (NG * GROUP_W == NUM_PINS);
  end
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  import gpio_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] line = '0;
  logic [31:0] gout, goe;
  logic [3:0]  irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .gpio_i(line), .gpio_o(gout), .gpio_oe_o(goe), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic settle_clear();
    cyc(4);
    wr(REG_EFLAG, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(REG_DIR, v);   chk("R1 dir", v, 32'hFFFF_FFFF);
    rd(REG_OUT, v);   chk("R1 out", v, 32'h0);
    rd(REG_INV, v);   chk("R1 inv", v, 32'h0);
    rd(REG_EFLAG, v); chk("R1 eflag", v, 32'h0);
    rd(REG_EEN, v);   chk("R1 een", v, 32'h0);
    rd(REG_LEN, v);   chk("R1 len", v, 32'h0);
    chk("R1 oe", goe, 32'h0);
    chk("R1 irq", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] v;
    line = 32'hA5A5_0F0F;
    cyc(1);
    rd(REG_DIN, v); chk("R2 latency", v, 32'h0);
    cyc(1);
    rd(REG_DIN, v); chk("R2 plain", v, 32'hA5A5_0F0F);
    wr(REG_INV, 32'hFFFF_0000);
    rd(REG_DIN, v); chk("R2 inverted", v, 32'h5A5A_0F0F);
    wr(REG_INV, 32'h0);
    line = '0;
    settle_clear();
  endtask

  task automatic t_output();
    logic [31:0] v;
    wr(REG_DIR, 32'hFFFF_00FF);
    wr(REG_OUT, 32'h1234_5678);
    line = 32'hFFFF_FFFF;
    cyc(3);
    rd(REG_DIN, v); chk("R3 mixed read", v, 32'hFFFF_56FF);
    chk("R3 gpio_o", gout, 32'h1234_5678);
    chk("R3 oe", goe, 32'h0000_FF00);
    wr(REG_DIR, 32'hFFFF_FFFF);
    wr(REG_OUT, 32'h0);
    line = '0;
    settle_clear();
  endtask

  task automatic t_level();
    wr(REG_LEN, 32'h0000_0100);
    line = 32'h0000_0300;
    cyc(4);
    chk("R4 level on", {28'h0, irq}, 32'h2);
    wr(REG_INV, 32'h0000_0100);
    cyc(2);
    chk("R4 level inverted off", {28'h0, irq}, 32'h0);
    wr(REG_INV, 32'h0);
    cyc(2);
    chk("R4 level back", {28'h0, irq}, 32'h2);
    line = '0;
    cyc(4);
    chk("R4 level released", {28'h0, irq}, 32'h0);
    wr(REG_LEN, 32'h0);
    settle_clear();
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(REG_EEN, 32'h0000_0001);
    line = 32'h1;
    cyc(4);
    rd(REG_EFLAG, v); chk("R5 rise sets", v, 32'h1);
    chk("R5 irq", {28'h0, irq}, 32'h1);
    line = 32'h0;
    cyc(4);
    rd(REG_EFLAG, v); chk("R6 sticky", v, 32'h1);
    chk("R6 irq held", {28'h0, irq}, 32'h1);
    wr(REG_INV, 32'h2);
    cyc(2);
    wr(REG_EFLAG, 32'h0);
    line = 32'h2;
    cyc(4);
    rd(REG_EFLAG, v); chk("R5 inverted rise ignored", v, 32'h0);
    line = 32'h0;
    cyc(4);
    rd(REG_EFLAG, v); chk("R5 inverted fall sets", v, 32'h2);
    wr(REG_INV, 32'h0);
    wr(REG_EEN, 32'h0);
    settle_clear();
  endtask

  task automatic t_clear();
    logic [31:0] v;
    line = 32'h0000_000C;
    cyc(4);
    rd(REG_EFLAG, v); chk("R6 two set", v, 32'hC);
    wr(REG_EFLAG, 32'hFFFF_FFF7);
    rd(REG_EFLAG, v); chk("R6 partial clear", v, 32'h4);
    wr(REG_EFLAG, 32'h0);
    rd(REG_EFLAG, v); chk("R6 full clear", v, 32'h0);
    line = '0;
    settle_clear();
  endtask

  task automatic t_emask();
    line = 32'h0001_0000;
    cyc(4);
    chk("R7 flag masked", {28'h0, irq}, 32'h0);
    wr(REG_EEN, 32'h0001_0000);
    cyc(1);
    chk("R7 edge enabled", {28'h0, irq}, 32'h4);
    wr(REG_EEN, 32'h0);
    wr(REG_LEN, 32'h0001_0000);
    cyc(1);
    chk("R7 level alone", {28'h0, irq}, 32'h4);
    line = '0;
    cyc(4);
    chk("R7 flag set but edge off", {28'h0, irq}, 32'h0);
    wr(REG_LEN, 32'h0);
    settle_clear();
  endtask

  task automatic t_groups();
    wr(REG_LEN, 32'hFFFF_FFFF);
    cyc(2);
    line = 32'h8000_0000; cyc(4);
    chk("R8 group3", {28'h0, irq}, 32'h8);
    line = 32'h0080_0000; cyc(4);
    chk("R8 group2", {28'h0, irq}, 32'h4);
    line = 32'h0100_0080; cyc(4);
    chk("R8 groups0and3", {28'h0, irq}, 32'h9);
    line = 32'h0; cyc(4);
    line = 32'h0000_0001;
    cyc(2);
    chk("R8 not yet", {28'h0, irq}, 32'h0);
    cyc(1);
    chk("R8 third edge", {28'h0, irq}, 32'h1);
    line = '0;
    wr(REG_LEN, 32'h0);
    settle_clear();
  endtask

  task automatic t_inv_edge();
    logic [31:0] v;
    wr(REG_INV, 32'h0000_0020);
    cyc(2);
    rd(REG_EFLAG, v); chk("R9 inversion edge", v, 32'h20);
    wr(REG_INV, 32'h0);
    settle_clear();
  endtask

  task automatic t_race();
    logic [31:0] v;
    line = 32'h0000_0040;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    addr = REG_EFLAG; wdata = 32'h0; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    rd(REG_EFLAG, v); chk("R10 edge beats clear", v, 32'h40);
    line = '0;
    settle_clear();
    rd(REG_EFLAG, v); chk("R10 later clear", v, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(REG_OUT, 32'hDEAD_BEEF); rd(REG_OUT, v); chk("R11 out", v, 32'hDEAD_BEEF);
    wr(REG_DIR, 32'hF0F0_F0F0); rd(REG_DIR, v); chk("R11 dir", v, 32'hF0F0_F0F0);
    wr(REG_EEN, 32'h1357_9BDF); rd(REG_EEN, v); chk("R11 een", v, 32'h1357_9BDF);
    wr(REG_LEN, 32'h0246_8ACE); rd(REG_LEN, v); chk("R11 len", v, 32'h0246_8ACE);
    wr(REG_EEN, 32'h0); wr(REG_LEN, 32'h0);
    wr(REG_INV, 32'h0F00_0000); rd(REG_INV, v); chk("R11 inv", v, 32'h0F00_0000);
    wr(REG_INV, 32'h0);
    wr(REG_DIN, 32'hFFFF_FFFF);
    rd(REG_OUT, v); chk("R11 din write ignored out", v, 32'hDEAD_BEEF);
    rd(REG_DIR, v); chk("R11 din write ignored dir", v, 32'hF0F0_F0F0);
    rd(5'h1C, v);   chk("R11 unmapped", v, 32'h0);
    wr(REG_DIR, 32'hFFFF_FFFF);
    wr(REG_OUT, 32'h0);
    settle_clear();
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_input();
    t_output();
    t_level();
    t_edge();
    t_clear();
    t_emask();
    t_groups();
    t_inv_edge();
    t_race();
    t_regs();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog got timeout exp completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule